// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's cells alive and holds normal traffic back until the device is ready. It sits beside the access controller and takes the RAS, CAS and address pins only for refresh cycles. An interval timer posts one refresh every `INTERVAL_CYC` clocks. That is about 15.6 µs, which covers 512 rows inside an 8 ms retention window. Refreshes that cannot run at once are held in a saturating pending counter. The scheduler asks for the bus with `ref_req`. It starts a cycle only when the controller returns `ref_gnt` and reports through `ctl_precharged` that RAS is high and precharged.

The `MODE` parameter picks the refresh style. In row-addressed mode (`RFS_RAS_ONLY`), an internal row counter drives the address while RAS is pulsed and CAS stays high. In the CAS-first style (`RFS_CBR`), CAS falls ahead of RAS and stays low until RAS rises, and the address bus is held at zero.

After reset the block waits `PWR_CYC` clocks. It then runs `WARM_CNT` refresh cycles as a warm-up before it raises `ready`. If refreshes were postponed beyond the pending budget, the retention period is treated as broken. In that case `ready` drops and the warm-up burst is repeated.

The states are ST_POWERUP, ST_IDLE, ST_ARB, ST_CAS_LEAD, ST_RAS_LOW and ST_PRECH. The transitions are:
- ST_POWERUP to ST_IDLE when the wait ends.
- ST_IDLE to ST_ARB when warm-up or pending work exists.
- ST_ARB to ST_CAS_LEAD (CAS-first style) or ST_RAS_LOW (row-addressed mode) on grant with precharge.
- ST_CAS_LEAD to ST_RAS_LOW after `CAS_LEAD_CYC`.
- ST_RAS_LOW to ST_PRECH after `RAS_LOW_CYC`.
- ST_PRECH to ST_IDLE after `PRECH_CYC`.

Top module: `rfs_scheduler`

## Requirements
- R1: After reset release, `ras_n`, `cas_n` are 1, `ready`, `ref_req`, `ref_active` are 0, and no RAS cycle occurs during the first `PWR_CYC` clocks.
- R2: After the power-up wait, exactly `WARM_CNT` refresh cycles run before `ready` rises.
- R3: Each `INTERVAL_CYC` clocks after power-up adds one pending refresh; while work is pending and no cycle runs, `ref_req` is 1.
- R4: A refresh cycle (rise of `ref_active`) starts only in the cycle after one where `ref_req`, `ref_gnt` and `ctl_precharged` were all 1.
- R5: In row-addressed mode `ras_n` stays low for exactly `RAS_LOW_CYC` clocks, and `cas_n` stays 1 throughout. `addr` carries the row counter, which advances by one per cycle and wraps from 2^ROW_W-1 to 0, starting at 0.
- R6: In the CAS-first style `cas_n` is low for exactly `CAS_LEAD_CYC` clocks before `ras_n` falls and stays low while `ras_n` is low. `addr` is 0.
- R7: Between any RAS low period and the next, `ras_n` stays high for at least `PRECH_CYC` clocks.
- R8: Postponed refreshes are made up back to back once the grant returns. The pending count saturates at `PEND_MAX`.
- R9: A timer period that ends with `PEND_MAX` refreshes already pending drops `ready` at once. It re-runs the `WARM_CNT` warm-up, with no power-up wait, before `ready` rises again.
- R10: `ras_n` or `cas_n` is low, or `addr` is non-zero, only while `ref_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the power-up wait |
| ref_gnt | input | 1 | Grant from the access controller |
| ctl_precharged | input | 1 | Controller reports RAS high and precharged |
| ref_req | output | 1 | Refresh bus request |
| ref_active | output | 1 | Scheduler owns the DRAM pins |
| ready | output | 1 | Normal accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr | output | ROW_W | Row address during refresh, zero otherwise |

## Verification
Some properties are checked on every cycle:
- The precharge gap before each RAS fall, held by a counter.
- The CAS/RAS ordering for the selected style.
- Start-only-on-grant.
- Pins quiet outside `ref_active`.
- Pending-counter bounds.
- Row-counter stepping.

Some behaviour only the directed scenarios can show:
- The counts of cycles in the warm-up and re-warm-up bursts.
- The one-refresh-per-period rate.
- The catch-up of postponed refreshes.
- Row wrap-around over a long run.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [2:0] {
        ST_POWERUP  = 3'd0,
        ST_IDLE     = 3'd1,
        ST_ARB      = 3'd2,
        ST_CAS_LEAD = 3'd3,
        ST_RAS_LOW  = 3'd4,
        ST_PRECH    = 3'd5
    } rfs_state_t;

    typedef enum logic {
        RFS_RAS_ONLY = 1'b0,
        RFS_CBR      = 1'b1
    } rfs_mode_t;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (!en || cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: a period never produces two ticks in a row
    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (INTERVAL_CYC > 1 && tick) |=> !tick);
endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic overflow
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] LIMIT = PW'(PEND_MAX);

    logic [PW-1:0] cnt_q;

    assign nonzero  = (cnt_q != '0);
    assign overflow = inc && !dec && (cnt_q == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> cnt_q == LIMIT);
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_q;

    assign row = row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (step) begin
            row_q <= row_q + 1'b1;
        end
    end

    assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> row_q == ROW_W'($past(row_q) + 1'b1));
    assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row_q));
endmodule

// File: rtl/rfs_scheduler.sv
module rfs_scheduler
    import rfs_pkg::*;
#(
    parameter rfs_mode_t MODE         = RFS_RAS_ONLY,
    parameter int        ROW_W        = 9,
    parameter int        INTERVAL_CYC = 1560,
    parameter int        PWR_CYC      = 10000,
    parameter int        WARM_CNT     = 8,
    parameter int        RAS_LOW_CYC  = 8,
    parameter int        PRECH_CYC    = 6,
    parameter int        CAS_LEAD_CYC = 1,
    parameter int        PEND_MAX     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    input  logic             ctl_precharged,
    output logic             ref_req,
    output logic             ref_active,
    output logic             ready,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] addr
);
    localparam int PH_MAX0 = (RAS_LOW_CYC > PRECH_CYC) ? RAS_LOW_CYC : PRECH_CYC;
    localparam int PH_MAX  = (PH_MAX0 > CAS_LEAD_CYC) ? PH_MAX0 : CAS_LEAD_CYC;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int PWW     = $clog2(PWR_CYC + 1);
    localparam int WMW     = $clog2(WARM_CNT + 1);
    localparam int HIW     = $clog2(PRECH_CYC + 1);
    localparam bit IS_CBR  = (MODE == RFS_CBR);

    rfs_state_t       state_q, state_d;
    logic [PH_W-1:0]  ph_q, ph_load;
    logic [PWW-1:0]   pw_q;
    logic [WMW-1:0]   warm_q;
    logic             tick, pend_nz, pend_ovf, cyc_done, row_step;
    logic [ROW_W-1:0] row_q;

    rfs_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q != ST_POWERUP),
        .tick  (tick)
    );

    assign cyc_done = (state_q == ST_PRECH) && (ph_q == '0);

    rfs_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (tick),
        .dec      (cyc_done && warm_q == '0),
        .nonzero  (pend_nz),
        .overflow (pend_ovf)
    );

    assign row_step = cyc_done && !IS_CBR;

    rfs_row_ctr #(.ROW_W(ROW_W)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_step),
        .row   (row_q)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERUP:  if (pw_q == '0) state_d = ST_IDLE;
            ST_IDLE:     if (warm_q != '0 || pend_nz) state_d = ST_ARB;
            ST_ARB:      if (ref_gnt && ctl_precharged)
                             state_d = IS_CBR ? ST_CAS_LEAD : ST_RAS_LOW;
            ST_CAS_LEAD: if (ph_q == '0) state_d = ST_RAS_LOW;
            ST_RAS_LOW:  if (ph_q == '0) state_d = ST_PRECH;
            ST_PRECH:    if (ph_q == '0) state_d = ST_IDLE;
            default:     state_d = ST_POWERUP;
        endcase
    end

    always_comb begin
        unique case (state_d)
            ST_CAS_LEAD: ph_load = PH_W'(CAS_LEAD_CYC - 1);
            ST_RAS_LOW:  ph_load = PH_W'(RAS_LOW_CYC - 1);
            ST_PRECH:    ph_load = PH_W'(PRECH_CYC - 1);
            default:     ph_load = '0;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
            ph_q    <= '0;
            pw_q    <= PWW'(PWR_CYC - 1);
            warm_q  <= WMW'(WARM_CNT);
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                ph_q <= ph_load;
            end else if (ph_q != '0) begin
                ph_q <= ph_q - 1'b1;
            end
            if (state_q == ST_POWERUP && pw_q != '0) begin
                pw_q <= pw_q - 1'b1;
            end
            if (pend_ovf) begin
                warm_q <= WMW'(WARM_CNT);
            end else if (cyc_done && warm_q != '0) begin
                warm_q <= warm_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ras_n      = 1'b1;
        cas_n      = 1'b1;
        addr       = '0;
        ref_req    = 1'b0;
        ref_active = 1'b0;
        unique case (state_q)
            ST_ARB: ref_req = 1'b1;
            ST_CAS_LEAD: begin
                cas_n      = 1'b0;
                ref_active = 1'b1;
            end
            ST_RAS_LOW: begin
                ras_n      = 1'b0;
                ref_active = 1'b1;
                if (IS_CBR) cas_n = 1'b0;
                else        addr  = row_q;
            end
            ST_PRECH: ref_active = 1'b1;
            default: ;
        endcase
    end

    assign ready = (state_q != ST_POWERUP) && (warm_q == '0);

    // precharge-gap observer for the R7 check
    logic [HIW-1:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= HIW'(PRECH_CYC);
        end else if (!ras_n) begin
            hi_q <= '0;
        end else if (hi_q != HIW'(PRECH_CYC)) begin
            hi_q <= hi_q + 1'b1;
        end
    end

    assert_prech_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_q >= HIW'(PRECH_CYC));
    assert_start_on_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_active) |-> $past(ref_req && ref_gnt && ctl_precharged));
    assert_quiet_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_active |-> (ras_n && cas_n && addr == '0));
    assert_quiet_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POWERUP) |-> (!ready && !ref_req && ras_n));

    generate
        if (IS_CBR) begin : g_cbr_chk
            assert_cas_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
            assert_cas_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> !cas_n);
        end else begin : g_row_chk
            assert_cas_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> cas_n);
        end
    endgenerate
endmodule

// File: tb/test_rfs_scheduler.sv
module rfs_bus_mon #(
    parameter int ROW_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             act,
    input logic [ROW_W-1:0] addr
);
    int falls, last_addr, min_low, max_low, min_gap, min_lead, max_lead;
    int casl_in_ras, cash_in_ras, nact;
    int hi_run, low_run, lead_run;
    logic prev_ras;

    always @(negedge clk) begin
        if (!rst_n) begin
            falls = 0; last_addr = -1; min_low = 1000; max_low = 0;
            min_gap = 1000; min_lead = 1000; max_lead = 0;
            casl_in_ras = 0; cash_in_ras = 0; nact = 0;
            hi_run = 1000; low_run = 0; lead_run = 0; prev_ras = 1'b1;
        end else begin
            if (prev_ras && !ras_n) begin
                falls++;
                last_addr = int'(addr);
                if (hi_run < min_gap) min_gap = hi_run;
                if (lead_run < min_lead) min_lead = lead_run;
                if (lead_run > max_lead) max_lead = lead_run;
            end
            if (!prev_ras && ras_n) begin
                if (low_run < min_low) min_low = low_run;
                if (low_run > max_low) max_low = low_run;
                low_run = 0;
            end
            if (ras_n) begin
                hi_run++;
                if (!cas_n) lead_run++;
                else lead_run = 0;
            end else begin
                hi_run = 0;
                lead_run = 0;
                low_run++;
                if (cas_n) cash_in_ras++;
                else casl_in_ras++;
            end
            if ((!ras_n || !cas_n || addr != '0) && !act) nact++;
            prev_ras = ras_n;
        end
    end
endmodule

module test_rfs_scheduler;
    import rfs_pkg::*;

    localparam int CLK_NS   = 10;
    localparam int ROWS_W   = 4;
    localparam int INTERVAL = 200;
    localparam int PWR      = 300;
    localparam int WARM     = 8;
    localparam int RASL     = 4;
    localparam int PRECH    = 3;
    localparam int LEAD     = 2;
    localparam int PMAX     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // instance in row-addressed mode
    logic auto_a = 1'b1, prech_a = 1'b1;
    logic req_a, act_a, rdy_a, ras_a, cas_a, gnt_a;
    logic [ROWS_W-1:0] addr_a;
    assign gnt_a = auto_a & req_a;

    rfs_scheduler #(
        .MODE(RFS_RAS_ONLY), .ROW_W(ROWS_W), .INTERVAL_CYC(INTERVAL),
        .PWR_CYC(PWR), .WARM_CNT(WARM), .RAS_LOW_CYC(RASL),
        .PRECH_CYC(PRECH), .CAS_LEAD_CYC(LEAD), .PEND_MAX(PMAX)
    ) i_rfs_scheduler (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_a), .ctl_precharged(prech_a),
        .ref_req(req_a), .ref_active(act_a), .ready(rdy_a),
        .ras_n(ras_a), .cas_n(cas_a), .addr(addr_a)
    );
    rfs_bus_mon #(.ROW_W(ROWS_W)) i_mon_a (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_a), .cas_n(cas_a), .act(act_a), .addr(addr_a)
    );

    // instance in CAS-first style, always granted
    logic req_b, act_b, rdy_b, ras_b, cas_b;
    logic [ROWS_W-1:0] addr_b;

    rfs_scheduler #(
        .MODE(RFS_CBR), .ROW_W(ROWS_W), .INTERVAL_CYC(INTERVAL),
        .PWR_CYC(PWR), .WARM_CNT(WARM), .RAS_LOW_CYC(RASL),
        .PRECH_CYC(PRECH), .CAS_LEAD_CYC(LEAD), .PEND_MAX(PMAX)
    ) i_rfs_scheduler_cbr (
        .clk(clk), .rst_n(rst_n), .ref_gnt(req_b), .ctl_precharged(1'b1),
        .ref_req(req_b), .ref_active(act_b), .ready(rdy_b),
        .ras_n(ras_b), .cas_n(cas_b), .addr(addr_b)
    );
    rfs_bus_mon #(.ROW_W(ROWS_W)) i_mon_b (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_b), .cas_n(cas_b), .act(act_b), .addr(addr_b)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready_a(input int limit);
        for (int i = 0; i < limit && !rdy_a; i++) @(negedge clk);
    endtask

    // align just after a finished refresh cycle of instance A
    task automatic sync_after_cycle_a();
        int f0 = i_mon_a.falls;
        for (int i = 0; i < 1000 && i_mon_a.falls == f0; i++) @(negedge clk);
        for (int i = 0; i < 100 && act_a; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        cyc(1);
        chk(ras_a && cas_a, "R1", "strobes high after reset", {ras_a, cas_a}, 3);
        chk(!rdy_a && !req_a, "R1", "ready/req low after reset", {rdy_a, req_a}, 0);
        chk(!act_a && addr_a == '0, "R10", "inactive bus after reset", int'(addr_a), 0);
        cyc(PWR - 10);
        chk(i_mon_a.falls == 0, "R1", "no RAS during power-up wait", i_mon_a.falls, 0);
        chk(!rdy_a && !rdy_b, "R1", "not ready during power-up", {rdy_a, rdy_b}, 0);
    endtask

    task automatic t_warmup_a();
        wait_ready_a(2000);
        chk(rdy_a, "R2", "ready rose", rdy_a, 1);
        chk(i_mon_a.falls == WARM, "R2", "warm-up cycles before ready", i_mon_a.falls, WARM);
        chk(i_mon_a.last_addr == WARM - 1, "R5", "row after warm-up", i_mon_a.last_addr, WARM - 1);
        chk(i_mon_a.min_low == RASL && i_mon_a.max_low == RASL, "R5", "RAS low width",
            i_mon_a.max_low, RASL);
        chk(i_mon_a.casl_in_ras == 0, "R5", "CAS low during RAS", i_mon_a.casl_in_ras, 0);
        chk(i_mon_a.min_gap >= PRECH, "R7", "precharge gap", i_mon_a.min_gap, PRECH);
    endtask

    task automatic t_cbr();
        for (int i = 0; i < 2000 && !rdy_b; i++) @(negedge clk);
        chk(i_mon_b.falls == WARM, "R2", "CAS-first warm-up cycles", i_mon_b.falls, WARM);
        chk(i_mon_b.min_lead == LEAD && i_mon_b.max_lead == LEAD, "R6", "CAS lead",
            i_mon_b.max_lead, LEAD);
        chk(i_mon_b.cash_in_ras == 0, "R6", "CAS high during RAS", i_mon_b.cash_in_ras, 0);
        chk(i_mon_b.last_addr == 0, "R6", "address zero", i_mon_b.last_addr, 0);
    endtask

    task automatic t_periodic_a();
        int f0, a0;
        sync_after_cycle_a();
        f0 = i_mon_a.falls;
        a0 = i_mon_a.last_addr;
        cyc(5 * INTERVAL);
        chk(i_mon_a.falls - f0 == 5, "R3", "one refresh per period", i_mon_a.falls - f0, 5);
        chk(((i_mon_a.last_addr - a0 + 16) % 16) == 5, "R5", "rows advanced",
            (i_mon_a.last_addr - a0 + 16) % 16, 5);
    endtask

    task automatic t_postpone_a();
        int f0;
        sync_after_cycle_a();
        auto_a = 1'b0;
        f0 = i_mon_a.falls;
        cyc(3 * INTERVAL);
        chk(i_mon_a.falls == f0, "R4", "no cycle without grant", i_mon_a.falls - f0, 0);
        chk(req_a && !act_a, "R3", "request held while pending", req_a, 1);
        auto_a = 1'b1;
        prech_a = 1'b0;
        cyc(40);
        chk(i_mon_a.falls == f0, "R4", "no cycle without precharge", i_mon_a.falls - f0, 0);
        prech_a = 1'b1;
        cyc(40);
        chk(i_mon_a.falls - f0 == 3, "R8", "postponed refreshes made up",
            i_mon_a.falls - f0, 3);
        chk(rdy_a, "R8", "ready kept within budget", rdy_a, 1);
    endtask

    task automatic t_overflow_a();
        int f0;
        sync_after_cycle_a();
        auto_a = 1'b0;
        cyc(900);
        chk(rdy_a, "R8", "ready at saturation", rdy_a, 1);
        cyc(100);
        chk(!rdy_a, "R9", "ready dropped on overflow", rdy_a, 0);
        f0 = i_mon_a.falls;
        auto_a = 1'b1;
        wait_ready_a(500);
        chk(i_mon_a.falls - f0 == WARM, "R9", "re-warm-up cycles", i_mon_a.falls - f0, WARM);
        cyc(60);
        chk(i_mon_a.falls - f0 == WARM + PMAX, "R8", "saturated backlog",
            i_mon_a.falls - f0, WARM + PMAX);
        chk(i_mon_a.falls > 16 && i_mon_a.last_addr == (i_mon_a.falls - 1) % 16, "R5",
            "row wrap", i_mon_a.last_addr, (i_mon_a.falls - 1) % 16);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_warmup_a();
        t_cbr();
        t_periodic_a();
        t_postpone_a();
        t_overflow_a();
        chk(i_mon_a.nact == 0 && i_mon_b.nact == 0, "R10", "pins quiet when inactive",
            i_mon_a.nact + i_mon_b.nact, 0);
        chk(i_mon_a.min_gap >= PRECH && i_mon_b.min_gap >= PRECH, "R7", "precharge gap overall",
            i_mon_b.min_gap, PRECH);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog all-R: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule